// File: doc/BRIEF.md
# Three-Wire Tuner Control Receiver

This block takes tuning words from a three-wire serial bus and turns them into the registered control fields of a synthesizer tuner. The bus has a serial clock, a serial data line and an enable line. The block samples all three with its own system clock. While enable is high, each rising edge of the serial clock shifts one data bit in, most significant bit first. When enable falls, the block decodes the most recent bits and loads its output registers. These hold four band-switch outputs, the main divider value, the swallow counter value and, for the extended word, the pump, test and reference-select control bits.

A three-bit mode input picks the word length and field layout. Code 1 uses an 18-bit word with a 9-bit main divider. Code 4 uses a 27-bit extended word. Codes 0, 2 and 3 use a 19-bit word. The parameter `SWAP_LEAD` builds a variant in which the first two band bits of the word trade places.

The decoded fields flow out as registers with a one-cycle `word_stb_o` pulse. The divider logic reloads on that pulse. There is no ready input and no back-pressure: a downstream consumer must take each word in the cycle the strobe is high. The fields then stay valid until the next strobe.

Top module: `tuner3w_rx`

## Requirements
- R1: During reset and after it, every field output is 0 and `word_stb_o` is 0 until the first accepted word.
- R2: A bit is shifted in, MSB first, on a rising edge of `bus_clk_i` only while `bus_en_i` is high. Serial-clock edges while enable is low change no output and give no strobe.
- R3: Field outputs change only when a word is accepted, within `SYNC_STAGES`+2 system cycles after `bus_en_i` falls. At all other times they hold their values.
- R4: In modes 0, 2 and 3 the word is 19 bits. In send order it is: lead bit 0 (UHF switch), lead bit 1 (trap switch), high-VHF switch, low-VHF switch, main divider bits 9..0, swallow bits 4..0.
- R5: In mode 1 the word is 18 bits. The main divider field is 9 bits (8..0) and main divider bit 9 is output as 0. The other fields keep their 19-bit order.
- R6: In mode 4 the word is 27 bits. The first 19 bits follow the R4 layout. The last 8 bits, in send order, are: ignored, pump-high, test, pump-off, ignored, ref-select bit 1, ref-select bit 0, ignored.
- R7: A word accepted in a mode other than 4 leaves pump-high, test, pump-off and ref-select unchanged.
- R8: With `SWAP_LEAD`=1, lead bit 0 drives the trap switch and lead bit 1 drives the UHF switch. All other fields are unchanged.
- R9: Only the last N bits shifted in before enable falls are decoded, where N is the word length of the mode. Extra leading bits have no effect.
- R10: A word is discarded if fewer than N serial-clock rising edges were seen since enable rose. All outputs then hold their values and no strobe is given.
- R11: Mode codes 5, 6 and 7 are reserved. A word ending in one of these modes is discarded: outputs hold their values and no strobe is given.
- R12: `word_stb_o` is high for exactly one system cycle for each accepted word. This is the same cycle in which the new field values first appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Serial bus clock (asynchronous) |
| bus_data_i | input | 1 | Serial bus data (asynchronous) |
| bus_en_i | input | 1 | Serial bus enable (asynchronous) |
| mode_i | input | 3 | Word length and layout select |
| sw_uhf_o | output | 1 | UHF band switch, active high |
| sw_trap_o | output | 1 | Trap switch, active high |
| sw_vhi_o | output | 1 | High-VHF band switch, active high |
| sw_vlo_o | output | 1 | Low-VHF band switch, active high |
| main_div_o | output | 10 | Main divider value |
| swallow_o | output | 5 | Swallow counter value |
| pump_hi_o | output | 1 | Charge pump high-current select |
| test_o | output | 1 | Test mode select |
| pump_off_o | output | 1 | Charge pump disable |
| ref_sel_o | output | 2 | Reference divider select bits |
| word_stb_o | output | 1 | One-cycle pulse when new fields are loaded |

## Verification
The assertions take four things for granted about the inputs. `mode_i` stays steady from enable rising until the word is decoded. Enable stays low for more than `SYNC_STAGES`+2 system cycles after it falls. Every bus line holds its level for several system cycles, so the synchronized data is settled when a clock edge is seen. Enable does not rise again before the pending word has been decoded. The stimulus drives each bus phase for three system cycles. It changes the mode only while enable is high and before the first clock edge, and it waits ten cycles after every enable fall. Within those rules, data words, modes and leading padding are drawn at random.

// File: rtl/tw3_pkg.sv
package tw3_pkg;
  localparam int M_W      = 10;
  localparam int S_W      = 5;
  localparam int BAND_N   = 4;
  localparam int TAIL_LEN = 8;
  localparam int BASE_LEN  = BAND_N + M_W + S_W;
  localparam int SHORT_LEN = BASE_LEN - 1;
  localparam int EXT_LEN   = BASE_LEN + TAIL_LEN;
  localparam int CNT_W     = $clog2(EXT_LEN + 1);

  localparam logic [2:0] MODE_FINE   = 3'd0;
  localparam logic [2:0] MODE_SHORT  = 3'd1;
  localparam logic [2:0] MODE_MID    = 3'd2;
  localparam logic [2:0] MODE_COARSE = 3'd3;
  localparam logic [2:0] MODE_EXT    = 3'd4;

  typedef struct packed {
    logic           sw_uhf;
    logic           sw_trap;
    logic           sw_vhi;
    logic           sw_vlo;
    logic [M_W-1:0] main_div;
    logic [S_W-1:0] swallow;
    logic           pump_hi;
    logic           test_en;
    logic           pump_off;
    logic [1:0]     ref_sel;
  } tune_word_t;

  function automatic logic [CNT_W-1:0] word_len(input logic [2:0] mode);
    case (mode)
      MODE_FINE, MODE_MID, MODE_COARSE: word_len = CNT_W'(BASE_LEN);
      MODE_SHORT:                       word_len = CNT_W'(SHORT_LEN);
      MODE_EXT:                         word_len = CNT_W'(EXT_LEN);
      default:                          word_len = '0;
    endcase
  endfunction
endpackage

// File: rtl/tw3_sync.sv
module tw3_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg[g] <= '0;
        end else begin
          if (g == 0) stg[g] <= d_i;
          else        stg[g] <= stg[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tw3_shift.sv
module tw3_shift
  import tw3_pkg::*;
#(
  parameter int DEPTH = EXT_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [DEPTH-1:0] word_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o  <= '0;
      count_o <= '0;
    end else begin
      if (start_i)                             count_o <= '0;
      else if (shift_i && count_o != CNT_MAX)  count_o <= count_o + 1'b1;
      if (shift_i) word_o <= {word_o[DEPTH-2:0], bit_i};
    end
  end
endmodule

// File: rtl/tw3_decode.sv
module tw3_decode
  import tw3_pkg::*;
#(
  parameter bit SWAP_LEAD = 1'b0
) (
  input  logic [EXT_LEN-1:0] word_i,
  input  logic [2:0]         mode_i,
  input  logic [CNT_W-1:0]   count_i,
  output tune_word_t         fields_o,
  output logic               accept_o,
  output logic               ext_o
);
  logic [BASE_LEN-1:0] base;
  logic [CNT_W-1:0]    need;
  logic                lead0, lead1;

  always_comb begin
    case (mode_i)
      MODE_SHORT: base = {word_i[SHORT_LEN-1 -: BAND_N], 1'b0, word_i[SHORT_LEN-BAND_N-1:0]};
      MODE_EXT:   base = word_i[EXT_LEN-1 -: BASE_LEN];
      default:    base = word_i[BASE_LEN-1:0];
    endcase
  end

  assign need     = word_len(mode_i);
  assign accept_o = (need != '0) && (count_i >= need);
  assign ext_o    = (mode_i == MODE_EXT);
  assign lead0    = base[BASE_LEN-1];
  assign lead1    = base[BASE_LEN-2];

  generate
    if (SWAP_LEAD) begin : g_swap
      assign fields_o.sw_uhf  = lead1;
      assign fields_o.sw_trap = lead0;
    end else begin : g_plain
      assign fields_o.sw_uhf  = lead0;
      assign fields_o.sw_trap = lead1;
    end
  endgenerate

  assign fields_o.sw_vhi   = base[BASE_LEN-3];
  assign fields_o.sw_vlo   = base[BASE_LEN-4];
  assign fields_o.main_div = base[S_W +: M_W];
  assign fields_o.swallow  = base[S_W-1:0];
  assign fields_o.pump_hi  = word_i[6];
  assign fields_o.test_en  = word_i[5];
  assign fields_o.pump_off = word_i[4];
  assign fields_o.ref_sel  = word_i[2:1];
endmodule

// File: rtl/tuner3w_rx.sv
module tuner3w_rx
  import tw3_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit SWAP_LEAD   = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_clk_i,
  input  logic           bus_data_i,
  input  logic           bus_en_i,
  input  logic [2:0]     mode_i,
  output logic           sw_uhf_o,
  output logic           sw_trap_o,
  output logic           sw_vhi_o,
  output logic           sw_vlo_o,
  output logic [M_W-1:0] main_div_o,
  output logic [S_W-1:0] swallow_o,
  output logic           pump_hi_o,
  output logic           test_o,
  output logic           pump_off_o,
  output logic [1:0]     ref_sel_o,
  output logic           word_stb_o
);
  logic [2:0]         sync_q;
  logic               clk_s, dat_s, en_s, clk_d, en_d;
  logic               clk_rise, en_rise, en_fall;
  logic [EXT_LEN-1:0] shift_word;
  logic [CNT_W-1:0]   bit_cnt;
  tune_word_t         dec_fields, held;
  logic               dec_accept, dec_ext;

  tw3_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({bus_en_i, bus_data_i, bus_clk_i}),
    .q_o(sync_q)
  );

  assign {en_s, dat_s, clk_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      en_d  <= 1'b0;
    end else begin
      clk_d <= clk_s;
      en_d  <= en_s;
    end
  end

  assign clk_rise = clk_s & ~clk_d;
  assign en_rise  = en_s & ~en_d;
  assign en_fall  = ~en_s & en_d;

  tw3_shift #(.DEPTH(EXT_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start_i(en_rise),
    .shift_i(clk_rise & en_s),
    .bit_i(dat_s),
    .word_o(shift_word),
    .count_o(bit_cnt)
  );

  tw3_decode #(.SWAP_LEAD(SWAP_LEAD)) u_dec (
    .word_i(shift_word),
    .mode_i(mode_i),
    .count_i(bit_cnt),
    .fields_o(dec_fields),
    .accept_o(dec_accept),
    .ext_o(dec_ext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held       <= '0;
      word_stb_o <= 1'b0;
    end else begin
      word_stb_o <= 1'b0;
      if (en_fall && dec_accept) begin
        held.sw_uhf   <= dec_fields.sw_uhf;
        held.sw_trap  <= dec_fields.sw_trap;
        held.sw_vhi   <= dec_fields.sw_vhi;
        held.sw_vlo   <= dec_fields.sw_vlo;
        held.main_div <= dec_fields.main_div;
        held.swallow  <= dec_fields.swallow;
        if (dec_ext) begin
          held.pump_hi  <= dec_fields.pump_hi;
          held.test_en  <= dec_fields.test_en;
          held.pump_off <= dec_fields.pump_off;
          held.ref_sel  <= dec_fields.ref_sel;
        end
        word_stb_o <= 1'b1;
      end
    end
  end

  assign sw_uhf_o   = held.sw_uhf;
  assign sw_trap_o  = held.sw_trap;
  assign sw_vhi_o   = held.sw_vhi;
  assign sw_vlo_o   = held.sw_vlo;
  assign main_div_o = held.main_div;
  assign swallow_o  = held.swallow;
  assign pump_hi_o  = held.pump_hi;
  assign test_o     = held.test_en;
  assign pump_off_o = held.pump_off;
  assign ref_sel_o  = held.ref_sel;
endmodule

// File: rtl/tw3_rx_chk.sv
module tw3_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_en_i,
  input logic [2:0]  mode_i,
  input logic        sw_uhf_o,
  input logic        sw_trap_o,
  input logic        sw_vhi_o,
  input logic        sw_vlo_o,
  input logic [9:0]  main_div_o,
  input logic [4:0]  swallow_o,
  input logic        pump_hi_o,
  input logic        test_o,
  input logic        pump_off_o,
  input logic [1:0]  ref_sel_o,
  input logic        word_stb_o
);
  logic [23:0] all_f;
  logic [4:0]  ctrl_f;
  assign all_f  = {sw_uhf_o, sw_trap_o, sw_vhi_o, sw_vlo_o, main_div_o, swallow_o,
                   pump_hi_o, test_o, pump_off_o, ref_sel_o};
  assign ctrl_f = {pump_hi_o, test_o, pump_off_o, ref_sel_o};

  p_stb_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |=> !word_stb_o);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb_o |-> $stable(all_f));

  p_latch_en_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |-> !$past(bus_en_i));

  p_ctrl_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb_o && $past(mode_i) != 3'd4) |-> $stable(ctrl_f));

  p_short_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb_o && $past(mode_i) == 3'd1) |-> !main_div_o[9]);

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb_o |-> $past(mode_i) <= 3'd4);
endmodule

bind tuner3w_rx tw3_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en_i(bus_en_i), .mode_i(mode_i),
  .sw_uhf_o(sw_uhf_o), .sw_trap_o(sw_trap_o), .sw_vhi_o(sw_vhi_o), .sw_vlo_o(sw_vlo_o),
  .main_div_o(main_div_o), .swallow_o(swallow_o), .pump_hi_o(pump_hi_o),
  .test_o(test_o), .pump_off_o(pump_off_o), .ref_sel_o(ref_sel_o),
  .word_stb_o(word_stb_o)
);

// File: tb/tuner3w_rx_tb_top.sv
module tuner3w_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, bdat = 1'b0, ben = 1'b0;
  logic [2:0] mode = 3'd0;

  always #2.5 clk = ~clk;

  logic        u0, t0, h0, l0, p0, x0, f0, s0b;
  logic [9:0]  m0;
  logic [4:0]  w0;
  logic [1:0]  r0;
  logic        u1, t1, h1, l1, p1, x1, f1, s1b;
  logic [9:0]  m1;
  logic [4:0]  w1;
  logic [1:0]  r1;

  tuner3w_rx #(.SYNC_STAGES(2), .SWAP_LEAD(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bclk), .bus_data_i(bdat), .bus_en_i(ben),
    .mode_i(mode), .sw_uhf_o(u0), .sw_trap_o(t0), .sw_vhi_o(h0), .sw_vlo_o(l0),
    .main_div_o(m0), .swallow_o(w0), .pump_hi_o(p0), .test_o(x0), .pump_off_o(f0),
    .ref_sel_o(r0), .word_stb_o(s0b));

  tuner3w_rx #(.SYNC_STAGES(2), .SWAP_LEAD(1'b1)) dut_sw_i (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bclk), .bus_data_i(bdat), .bus_en_i(ben),
    .mode_i(mode), .sw_uhf_o(u1), .sw_trap_o(t1), .sw_vhi_o(h1), .sw_vlo_o(l1),
    .main_div_o(m1), .swallow_o(w1), .pump_hi_o(p1), .test_o(x1), .pump_off_o(f1),
    .ref_sel_o(r1), .word_stb_o(s1b));

  wire [23:0] out0 = {u0, t0, h0, l0, m0, w0, p0, x0, f0, r0};
  wire [23:0] out1 = {u1, t1, h1, l1, m1, w1, p1, x1, f1, r1};

  int n_checks = 0, n_fail = 0;
  int stb0 = 0, stb1 = 0, exp_stb = 0;
  logic [23:0] exp0 = '0, exp1 = '0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (s0b) stb0++;
    if (s1b) stb1++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int len_of(input int md);
    if (md == 1) return 18;
    if (md == 4) return 27;
    if (md == 0 || md == 2 || md == 3) return 19;
    return 0;
  endfunction

  // Field model from the requirements (R4, R5, R6, R7, R8)
  function automatic logic [23:0] model(input logic [26:0] w, input int md, input bit swp,
                                        input logic [23:0] prev);
    logic [23:0] r;
    int b;
    r = prev;
    b = len_of(md) - 1;
    r[23] = swp ? w[b-1] : w[b];
    r[22] = swp ? w[b]   : w[b-1];
    r[21] = w[b-2];
    r[20] = w[b-3];
    if (md == 1) begin
      r[19:10] = {1'b0, w[13:5]};
      r[9:5]   = w[4:0];
    end else begin
      r[19:10] = w[b-4 -: 10];
      r[9:5]   = w[b-14 -: 5];
    end
    if (md == 4) begin
      r[4] = w[6]; r[3] = w[5]; r[2] = w[4]; r[1:0] = w[2:1];
    end
    return r;
  endfunction

  task automatic send(input logic [26:0] w, input int nbits, input int md);
    mode = 3'(md);
    ben  = 1'b1;
    tick(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      bdat = w[i];
      tick(3);
      bclk = 1'b1;
      tick(3);
      bclk = 1'b0;
    end
    tick(3);
    ben = 1'b0;
    tick(10);
    if (len_of(md) != 0 && nbits >= len_of(md)) begin
      exp0 = model(w, md, 1'b0, exp0);
      exp1 = model(w, md, 1'b1, exp1);
      exp_stb++;
    end
  endtask

  task automatic check_all(input string tag);
    check(out0 === exp0, {tag, " fields"}, 32'(out0), 32'(exp0));
    check(out1 === exp1, {tag, " R8 swapped fields"}, 32'(out1), 32'(exp1));
    check(stb0 == exp_stb, {tag, " R12 strobe count"}, 32'(stb0), 32'(exp_stb));
    check(stb1 == exp_stb, {tag, " R12 strobe count swap"}, 32'(stb1), 32'(exp_stb));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [26:0] w;
    int md;
    void'($urandom(32'd20240611));
    tick(3);
    check(out0 == 24'h0 && s0b == 1'b0, "R1 reset", 32'(out0), 32'h0);
    rst_n = 1'b1;
    tick(5);
    check(out0 == 24'h0 && out1 == 24'h0, "R1 after reset", 32'(out0), 32'h0);

    // Directed: R4 mode 0 walking pattern
    send(27'h5_3A5C, 19, 0);
    check_all("R4 mode0 directed");
    // R5 mode 1 all ones -> main div 0x1FF
    send(27'h3_FFFF, 18, 1);
    check_all("R5 mode1 all ones");
    check(m0 == 10'h1FF, "R5 main div top bit", 32'(m0), 32'h1FF);
    // R6 mode 4 with control bits set
    send(27'h7FF_FFFF, 27, 4);
    check_all("R6 mode4 all ones");
    // R7 non-extended word keeps control
    send(27'h0, 19, 3);
    check_all("R7 mode3 zeros");
    check(out0[4:0] == 5'h1F, "R7 ctrl held", 32'(out0[4:0]), 32'h1F);
    // R9 extra leading bits
    send(27'h7_0000 | 27'h1_2345, 22, 2);
    check_all("R9 leading padding");
    // R10 short word
    send(27'h3FF, 10, 0);
    check_all("R10 short word");
    send(27'h7FF_FFFF, 26, 4);
    check_all("R10 short extended");
    // R11 reserved modes
    send(27'h555_5555, 27, 6);
    check_all("R11 reserved mode6");
    send(27'h2AA_AAAA, 27, 7);
    check_all("R11 reserved mode7");
    // R2 clocks with enable low
    for (int i = 0; i < 30; i++) begin
      bdat = i[0];
      tick(3); bclk = 1'b1; tick(3); bclk = 1'b0;
    end
    tick(10);
    check_all("R2 clocks enable low");
    // Random words
    for (int k = 0; k < 40; k++) begin
      md = int'($urandom % 5);
      w  = 27'($urandom);
      send(w, len_of(md) + int'($urandom % 3) * ((md == 4) ? 0 : 1), md);
      case (md)
        1:       check_all("R5 random mode1");
        4:       check_all("R6 random mode4");
        default: check_all("R4 random base mode");
      endcase
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule